// File: doc/BRIEF.md
# RAM-Based Fixed Delay Line

This block delays a stream of data words by a fixed number of clock cycles. The words are kept in a memory array, not in a chain of flip-flops. Every cycle the incoming word is written into the memory, and an older word is read back out. The stored words never move. Only two address counters move: one selects where to write and the other selects where to read. This lets the storage scale with memory density rather than with register count.

The read counter restarts at the first entry and the write counter restarts at the last entry. Both advance by one each clock and wrap at the configured depth, so the write address always trails the read address by exactly one entry. The read data is registered. Seen from its ports, the block therefore acts as a shift register of DEPTH stages. A flag marks the output as meaningful once the memory has been filled once since reset.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, after that edge `dout` is all zeros and `dout_valid` is 0. The read counter is at entry 0 and the write counter is at entry DEPTH-1.
- R2: Outside reset, the write address always equals the read address minus one, modulo DEPTH.
- R3: Outside reset, each counter advances by one on every rising edge and wraps from DEPTH-1 to 0. This also holds when DEPTH is not a power of two.
- R4: Number the rising edges since reset release 1, 2, 3 and so on. After edge e, with e ≥ DEPTH, `dout` equals the `din` value sampled at edge e-DEPTH+1. This is the behaviour of a DEPTH-stage register chain.
- R5: `dout_valid` is 0 after the first DEPTH-1 edges following reset release. It is 1 from edge DEPTH onward and stays 1 until reset is applied again.
- R6: The read address and the write address differ in every cycle, so no bypass of a word being written is needed.
- R7: Applying reset in the middle of a stream drops `dout_valid` and restarts the fill count. After release, R4 and R5 hold again, counted from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | DATA_W | Word entering the delay line, sampled every edge |
| dout | output | DATA_W | Word leaving the delay line, registered |
| dout_valid | output | 1 | High once the line has been filled after reset |

## Verification
The bench builds two instances side by side. The first has DEPTH 5 and DATA_W 8, so the counters must wrap at a value that is not a power of two and the delay spans an odd number of cycles. The second has DEPTH 8 and DATA_W 4, so the wrap coincides with the natural counter roll-over. With such short lines, each counter wraps many times within a few hundred cycles, and a reset in mid-stream falls while the memory is already full of old data. That mid-stream reset shows that stale contents are never flagged as valid.

// File: rtl/ramdl_pkg.sv
// Package ramdl_pkg
// Shared helpers for the RAM-based delay line.
// Assumes: depth values are at least 2.
package ramdl_pkg;

    // Address width needed to index a given number of entries (minimum 1).
    function automatic int unsigned addr_w(input int unsigned depth);
        int unsigned w;
        w = $clog2(depth);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/ramdl_wrap_ctr.sv
// Module ramdl_wrap_ctr
// A free-running address counter. It counts 0..DEPTH-1 and wraps to 0.
// It loads RESET_VAL on a synchronous active-low reset.
// Assumes: RESET_VAL < DEPTH, DEPTH >= 2.
module ramdl_wrap_ctr #(
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned AW        = 6,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [AW-1:0] START = AW'(RESET_VAL);

    logic [AW-1:0] ptr_q;

    // Advance one entry per clock, wrapping at the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= START;
        else if (ptr_q == LAST)
            ptr_q <= '0;
        else
            ptr_q <= ptr_q + 1'b1;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/ramdl_store.sv
// Module ramdl_store
// A simple dual-port register array: one write and one registered read per
// clock. The array itself is not reset. The read register clears on reset.
// Assumes: the read and write addresses never match in a cycle, so a read
// never needs to see the word written in the same cycle.
module ramdl_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 64,
    parameter int unsigned AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Write the incoming word every cycle outside reset.
    always_ff @(posedge clk) begin
        if (rst_n)
            mem_q[wr_addr] <= wr_data;
    end

    // Register the word at the read address. It clears during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else
            rd_q <= mem_q[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/ramdl_fill_mon.sv
// Module ramdl_fill_mon
// Counts the edges since reset release, saturating at DEPTH-1. It raises
// the valid flag after the DEPTH-th edge, the first edge at which the word
// written after release reaches the output register.
// Assumes: DEPTH >= 2.
module ramdl_fill_mon #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic filled
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] cnt_q;
    logic          filled_q;

    // Saturating count of the edges seen since release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    // The flag follows the saturated count by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            filled_q <= 1'b0;
        else
            filled_q <= (cnt_q == LAST);
    end

    assign filled = filled_q;
endmodule

// File: rtl/ram_delay_line.sv
// Module ram_delay_line
// A fixed DEPTH-stage delay line whose words stay in place in a register
// array. Two wrapping counters, reset to entry 0 (read) and entry DEPTH-1
// (write), select the addresses. The output is registered.
// Assumes: DEPTH >= 2. The contents are meaningful only while dout_valid is 1.
module ram_delay_line #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);
    localparam int unsigned AW = ramdl_pkg::addr_w(DEPTH);

    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] wr_ptr;

    // Read counter starts at the first entry.
    ramdl_wrap_ctr #(.DEPTH(DEPTH), .AW(AW), .RESET_VAL(0)) rd_ctr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .ptr  (rd_ptr)
    );

    // Write counter starts at the last entry, one behind the reader.
    ramdl_wrap_ctr #(.DEPTH(DEPTH), .AW(AW), .RESET_VAL(DEPTH - 1)) wr_ctr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .ptr  (wr_ptr)
    );

    // Storage with a registered read.
    ramdl_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_addr(wr_ptr),
        .wr_data(din),
        .rd_addr(rd_ptr),
        .rd_data(dout)
    );

    // Valid flag after the first complete fill.
    ramdl_fill_mon #(.DEPTH(DEPTH), .AW(AW)) fill_i (
        .clk   (clk),
        .rst_n (rst_n),
        .filled(dout_valid)
    );
endmodule

// File: rtl/ram_delay_line_chk.sv
// Module ram_delay_line_chk
// Property checker bound to ram_delay_line. It watches both address counters
// and the valid flag, and uses its own edge counter for the fill window.
module ram_delay_line_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] rd_ptr,
    input logic [AW-1:0] wr_ptr,
    input logic          dout_valid
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   FULL = (AW + 1)'(DEPTH);

    logic [AW:0] edges_q;

    // Independent count of the edges since release, saturating at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)
            edges_q <= '0;
        else if (edges_q != FULL)
            edges_q <= edges_q + 1'b1;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_ptr == '0 && wr_ptr == LAST && !dout_valid));

    p_write_trails_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr == ((rd_ptr == '0) ? LAST : rd_ptr - 1'b1));

    p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr != LAST) |=> rd_ptr == $past(rd_ptr) + 1'b1);

    p_rd_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr == LAST) |=> rd_ptr == '0);

    p_wr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr == LAST) |=> wr_ptr == '0);

    p_fill_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid == (edges_q == FULL));

    p_valid_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> dout_valid);

    p_no_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr != wr_ptr);
endmodule

bind ram_delay_line ram_delay_line_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .dout_valid(dout_valid)
);

// File: tb/ram_delay_line_tb_top.sv
`timescale 1ns/1ps
module ram_delay_line_tb_top;
    localparam int D_A = 5;
    localparam int D_B = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din_a = '0;
    logic [3:0] din_b = '0;
    logic [7:0] dout_a;
    logic [3:0] dout_b;
    logic       val_a, val_b;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    bit  after_mid_rst = 0;

    always #2.5 clk = ~clk;

    ram_delay_line #(.DATA_W(8), .DEPTH(D_A)) dut_i (
        .clk(clk), .rst_n(rst_n), .din(din_a), .dout(dout_a), .dout_valid(val_a));

    ram_delay_line #(.DATA_W(4), .DEPTH(D_B)) dut_pow2_i (
        .clk(clk), .rst_n(rst_n), .din(din_b), .dout(dout_b), .dout_valid(val_b));

    // Behavioural reference: a history queue per instance.
    logic [7:0] hist_a[$];
    logic [3:0] hist_b[$];
    int         edges_a = 0, edges_b = 0;
    logic [7:0] exp_a = '0;
    logic [3:0] exp_b = '0;
    bit         expv_a = 0, expv_b = 0, in_rst = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist_a.delete(); hist_b.delete();
            edges_a = 0; edges_b = 0;
            expv_a = 0; expv_b = 0;
            exp_a = '0; exp_b = '0;
            in_rst = 1;
        end else begin
            in_rst = 0;
            hist_a.push_back(din_a);
            hist_b.push_back(din_b);
            if (hist_a.size() > D_A) void'(hist_a.pop_front());
            if (hist_b.size() > D_B) void'(hist_b.pop_front());
            edges_a++; edges_b++;
            expv_a = (edges_a >= D_A);
            expv_b = (edges_b >= D_B);
            if (hist_a.size() == D_A) exp_a = hist_a[0];
            if (hist_b.size() == D_B) exp_b = hist_b[0];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (!done) begin
            if (in_rst) begin
                check("R1 dout_a in reset", 32'(dout_a), 32'd0);
                check("R1 valid_a in reset", 32'(val_a), 32'd0);
                check("R1 dout_b in reset", 32'(dout_b), 32'd0);
                check("R1 valid_b in reset", 32'(val_b), 32'd0);
            end else begin
                check(after_mid_rst ? "R7 R5 valid_a" : "R5 valid_a", 32'(val_a), 32'(expv_a));
                check(after_mid_rst ? "R7 R5 valid_b" : "R5 valid_b", 32'(val_b), 32'(expv_b));
                if (expv_a)
                    check(after_mid_rst ? "R7 R4 dout_a" : "R4 R2 R3 R6 dout_a", 32'(dout_a), 32'(exp_a));
                if (expv_b)
                    check(after_mid_rst ? "R7 R4 dout_b" : "R4 R2 R3 R6 dout_b", 32'(dout_b), 32'(exp_b));
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Stimulus, driven on falling edges.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 40; i++) begin           // counting pattern
            din_a = 8'(i + 1); din_b = 4'(i + 1);
            @(negedge clk);
        end
        for (int i = 0; i < 60; i++) begin           // pseudo-random words
            din_a = 8'($urandom); din_b = 4'($urandom);
            @(negedge clk);
        end
        for (int i = 0; i < 20; i++) begin           // all-zeros / all-ones
            din_a = (i % 2 == 0) ? 8'hFF : 8'h00;
            din_b = (i % 2 == 0) ? 4'hF : 4'h0;
            @(negedge clk);
        end
        din_a = 8'h5A; din_b = 4'h9;                 // held constant
        repeat (10) @(negedge clk);
        rst_n = 1'b0;                                // mid-stream reset, R7
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        after_mid_rst = 1;
        for (int i = 0; i < 30; i++) begin
            din_a = 8'(200 - i); din_b = 4'(15 - (i % 16));
            @(negedge clk);
        end
        done = 1;
        summary();
        $finish;
    end

    // Watchdog: counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule